// File: doc/BRIEF.md
# Shift-Then-Add/Subtract Unit with Condition Flags

This block performs one add or subtract per accepted request. The second operand is taken from a register value after an immediate shift. The shift is either logical left, logical right or rotate right, by a 5-bit amount. The shift is applied first. The sum or difference, and from it the negative, zero, carry and overflow flags, are then formed on the shifted value.

The result and the flags are registered. A request is accepted on a rising clock edge while `inValid` is high. The result appears on `result` after that edge. The flags are updated only when `setFlags` is high. They are packed into the four top bits of `statusWord`, and every lower bit of that word reads zero.

Subtraction forms the difference as A plus the inverted shifted operand plus one. Carry therefore means that no borrow took place.

Top module: `shift_add_unit`

## Requirements
- R1: While `rstN` is low, and after it is released, `result` and `statusWord` are zero until the first accepted request.
- R2: An accepted request with `isSub`=0 makes `result` equal to `operandA` plus the shifted `operandB`, modulo 2^32, visible after the accepting edge.
- R3: Shift code 2'b00 shifts `operandB` left by `shiftAmt` and fills with zeros (0x08000000 shifted by 4 gives 0x80000000).
- R4: Shift code 2'b01 shifts `operandB` right by `shiftAmt` and fills with zeros (0x100 shifted by 2 gives 0x40).
- R5: Shift code 2'b11 rotates `operandB` right by `shiftAmt` (0x10000000 rotated by 4 gives 0x01000000).
- R6: A `shiftAmt` of 0 passes `operandB` unchanged for every shift code. Shift code 2'b10 is reserved and always passes `operandB` unchanged.
- R7: When flags are updated, N (`statusWord` bit 31) equals result bit 31 and Z (bit 30) is 1 exactly when the result is zero.
- R8: For an add, C (bit 29) is the carry out of bit 31 and V (bit 28) is signed overflow. For example, 0x80000000 + (0x08000000 shifted left by 4) gives 0 with N=0, Z=1, C=1, V=1.
- R9: With `isSub`=1, `result` is A minus the shifted B. C is 1 when no borrow occurs and 0 when one does, and V is signed overflow of the subtraction. For example, 0x10 − (0x100 shifted right by 2) gives 0xFFFFFFD0 with N=1, Z=0, C=0, V=0.
- R10: An accepted request with `setFlags`=0 updates `result` but leaves all four flags at their previous values.
- R11: While `inValid` is low, `result` and `statusWord` hold their values whatever the other inputs do.
- R12: Bits 27 down to 0 of `statusWord` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Accept a request on this edge |
| operandA | input | 32 | First operand, used as given |
| operandB | input | 32 | Operand that is shifted before the arithmetic |
| shiftKind | input | 2 | 00 left, 01 right, 11 rotate right, 10 reserved (pass) |
| shiftAmt | input | 5 | Immediate shift amount, 0 to 31 |
| isSub | input | 1 | 1 subtracts the shifted operand, 0 adds it |
| setFlags | input | 1 | 1 lets the request update the flags |
| result | output | 32 | Registered result of the last accepted request |
| statusWord | output | 32 | N, Z, C, V in bits 31..28, zeros below |

## Verification
The bench builds the unit with its default 32-bit data width and a derived 5-bit shift amount. This lets the three worked examples be applied as literal values. With this width, every shift amount from 0 to 31 is reachable in every barrel stage, including the largest single stage of 16. Random operands at this width reach the carry and overflow corners rarely on their own. For that reason, directed cases with the sign bits set sit alongside the random mix, and the random mix biases some operands toward the extreme values.

// File: rtl/shalu_pkg.sv
package shalu_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_RSV = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadResult;
    logic       loadFlags;
    logic       invertB;
    logic       carryIn;
    shiftKind_e shiftSel;
  } aluStrobe_t;
endpackage

// File: rtl/shalu_shifter.sv
module shalu_shifter
  import shalu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  operand,
  input  logic [SHAMT_W-1:0] shiftAmt,
  input  shiftKind_e         shiftSel,
  output logic [DATA_W-1:0]  shifted
);
  logic [DATA_W-1:0] stageVal [SHAMT_W+1];

  assign stageVal[0] = operand;

  // One barrel stage per amount bit, stage s moves by 2^s
  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [DATA_W-1:0] moved;
    always_comb begin
      case (shiftSel)
        SH_LSL:  moved = {stageVal[s][DATA_W-1-K:0], {K{1'b0}}};
        SH_LSR:  moved = {{K{1'b0}}, stageVal[s][DATA_W-1:K]};
        SH_ROR:  moved = {stageVal[s][K-1:0], stageVal[s][DATA_W-1:K]};
        default: moved = stageVal[s];
      endcase
    end
    assign stageVal[s+1] = shiftAmt[s] ? moved : stageVal[s];
  end

  assign shifted = stageVal[SHAMT_W];
endmodule

// File: rtl/shalu_ctrl.sv
module shalu_ctrl
  import shalu_pkg::*;
(
  input  logic       inValid,
  input  logic       setFlags,
  input  logic       isSub,
  input  logic [1:0] shiftKind,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe.loadResult = inValid;
    strobe.loadFlags  = inValid & setFlags;
    strobe.invertB    = isSub;
    strobe.carryIn    = isSub;
    strobe.shiftSel   = shiftKind_e'(shiftKind);
  end
endmodule

// File: rtl/shalu_datapath.sv
module shalu_datapath
  import shalu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  aluStrobe_t         strobe,
  input  logic [DATA_W-1:0]  operandA,
  input  logic [DATA_W-1:0]  operandB,
  input  logic [SHAMT_W-1:0] shiftAmt,
  output logic [DATA_W-1:0]  result,
  output logic [DATA_W-1:0]  statusWord
);
  localparam int FLAG_N = 4;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] shiftedB;
  logic [DATA_W-1:0] addendB;
  logic [DATA_W:0]   wideSum;
  logic [DATA_W-1:0] sumVal;
  logic [FLAG_N-1:0] flagsNext;
  logic [DATA_W-1:0] resultQ;
  logic [FLAG_N-1:0] flagsQ;

  shalu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .operand  (operandB),
    .shiftAmt (shiftAmt),
    .shiftSel (strobe.shiftSel),
    .shifted  (shiftedB)
  );

  // Subtract as A + ~B + 1 so carry reads as "no borrow"
  assign addendB = strobe.invertB ? ~shiftedB : shiftedB;
  assign wideSum = {1'b0, operandA} + {1'b0, addendB}
                 + {{DATA_W{1'b0}}, strobe.carryIn};
  assign sumVal  = wideSum[MSB:0];

  always_comb begin
    flagsNext[3] = sumVal[MSB];
    flagsNext[2] = (sumVal == '0);
    flagsNext[1] = wideSum[DATA_W];
    flagsNext[0] = (operandA[MSB] == addendB[MSB]) && (sumVal[MSB] != operandA[MSB]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else begin
      if (strobe.loadResult) resultQ <= sumVal;
      if (strobe.loadFlags)  flagsQ  <= flagsNext;
    end
  end

  assign result     = resultQ;
  assign statusWord = {flagsQ, {(DATA_W-FLAG_N){1'b0}}};
endmodule

// File: rtl/shift_add_unit.sv
module shift_add_unit
  import shalu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  operandA,
  input  logic [DATA_W-1:0]  operandB,
  input  logic [1:0]         shiftKind,
  input  logic [SHAMT_W-1:0] shiftAmt,
  input  logic               isSub,
  input  logic               setFlags,
  output logic [DATA_W-1:0]  result,
  output logic [DATA_W-1:0]  statusWord
);
  aluStrobe_t strobe;

  shalu_ctrl u_ctrl (
    .inValid   (inValid),
    .setFlags  (setFlags),
    .isSub     (isSub),
    .shiftKind (shiftKind),
    .strobe    (strobe)
  );

  shalu_datapath #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .operandA   (operandA),
    .operandB   (operandB),
    .shiftAmt   (shiftAmt),
    .result     (result),
    .statusWord (statusWord)
  );
endmodule

// File: rtl/shift_add_unit_chk.sv
module shift_add_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               setFlags,
  input logic               isSub,
  input logic [SHAMT_W-1:0] shiftAmt,
  input logic [DATA_W-1:0]  operandA,
  input logic [DATA_W-1:0]  operandB,
  input logic [DATA_W-1:0]  result,
  input logic [DATA_W-1:0]  statusWord
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(statusWord))); // R11

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !setFlags) |=> $stable(statusWord)); // R10

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[DATA_W-5:0] == '0); // R12

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && setFlags) |=> (statusWord[DATA_W-2] == (result == '0))); // R7

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && setFlags) |=> (statusWord[DATA_W-1] == result[DATA_W-1])); // R7

  AST_ZERO_SHIFT_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isSub && shiftAmt == '0)
      |=> (result == $past(operandA) + $past(operandB))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (result == '0 && statusWord == '0)); // R1
endmodule

bind shift_add_unit shift_add_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .setFlags   (setFlags),
  .isSub      (isSub),
  .shiftAmt   (shiftAmt),
  .operandA   (operandA),
  .operandB   (operandB),
  .result     (result),
  .statusWord (statusWord)
);

// File: tb/sim_shift_add_unit.sv
`timescale 1ns/1ps
module sim_shift_add_unit;
  localparam int W  = 32;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  operandA = '0;
  logic [W-1:0]  operandB = '0;
  logic [1:0]    shiftKind = 2'b00;
  logic [SW-1:0] shiftAmt = '0;
  logic          isSub = 1'b0;
  logic          setFlags = 1'b0;
  logic [W-1:0]  result;
  logic [W-1:0]  statusWord;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] expFlags = 4'b0000;
  logic [W-1:0] expResult = '0;

  always #4 clk = ~clk;

  shift_add_unit #(.DATA_W(W), .SHAMT_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operandA(operandA),
    .operandB(operandB), .shiftKind(shiftKind), .shiftAmt(shiftAmt),
    .isSub(isSub), .setFlags(setFlags), .result(result), .statusWord(statusWord)
  );

  function automatic logic [W-1:0] refShift(logic [W-1:0] b, logic [1:0] k, int amt);
    logic [2*W-1:0] dbl;
    dbl = {b, b} >> amt;
    case (k)
      2'b00:   return b << amt;
      2'b01:   return b >> amt;
      2'b11:   return dbl[W-1:0];
      default: return b;
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] k, int amt,
                      logic sub, logic sf, string tag);
    logic [W-1:0] sh;
    logic [W-1:0] r;
    logic c, v;
    @(negedge clk);
    operandA = a; operandB = b; shiftKind = k; shiftAmt = SW'(amt);
    isSub = sub; setFlags = sf; inValid = 1'b1;
    sh = refShift(b, k, amt);
    if (sub) begin
      r = a - sh;
      c = (a >= sh);
      v = (a[W-1] != sh[W-1]) && (r[W-1] != a[W-1]);
    end else begin
      {c, r} = {1'b0, a} + {1'b0, sh};
      v = (a[W-1] == sh[W-1]) && (r[W-1] != a[W-1]);
    end
    expResult = r;
    if (sf) expFlags = {r[W-1], r == '0, c, v};
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " result"}, result, expResult);
    check({tag, " status (R12 low bits)"}, statusWord, {expFlags, 28'h0});
  endtask

  initial begin : watchdog
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset result", result, '0);
    check("R1 reset status", statusWord, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", statusWord | result, '0);

    // Worked examples
    doOp(32'h8000_0000, 32'h0800_0000, 2'b00, 4, 1'b0, 1'b1, "R8 R3 add lsl");
    check("R8 flags NZCV=0111", statusWord, 32'h7000_0000);
    doOp(32'h10, 32'h100, 2'b01, 2, 1'b1, 1'b1, "R9 R4 sub lsr");
    check("R9 result", result, 32'hFFFF_FFD0);
    check("R9 flags NZCV=1000", statusWord, 32'h8000_0000);
    doOp(32'h0, 32'h1000_0000, 2'b11, 4, 1'b0, 1'b1, "R5 add ror");
    check("R5 result", result, 32'h0100_0000);
    check("R5 flags clear", statusWord, 32'h0);

    // Zero amount and reserved code
    doOp(32'h1234_5678, 32'hF000_000F, 2'b11, 0, 1'b0, 1'b1, "R6 ror amt0");
    doOp(32'h1, 32'hABCD_0001, 2'b10, 7, 1'b0, 1'b1, "R6 reserved code");
    doOp(32'h5, 32'h5, 2'b00, 0, 1'b1, 1'b1, "R9 R7 equal sub zero");
    doOp(32'h7FFF_FFFF, 32'h1, 2'b00, 0, 1'b0, 1'b1, "R8 pos overflow");
    doOp(32'h8000_0000, 32'h1, 2'b00, 0, 1'b1, 1'b1, "R9 sub overflow");
    doOp(32'h0, 32'h8000_0001, 2'b11, 31, 1'b0, 1'b1, "R5 ror 31");

    // Flags kept when set-flags is low
    doOp(32'hFFFF_FFFF, 32'h1, 2'b00, 0, 1'b0, 1'b1, "R8 carry to zero");
    doOp(32'h1, 32'h1, 2'b00, 3, 1'b0, 1'b0, "R10 no flag update");

    // Idle hold
    begin
      logic [W-1:0] rHold, sHold;
      rHold = result; sHold = statusWord;
      @(negedge clk);
      operandA = 32'hDEAD_BEEF; operandB = 32'h1; setFlags = 1'b1; isSub = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 idle result", result, rHold);
      check("R11 idle status", statusWord, sHold);
    end

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      logic [1:0] k;
      a = $urandom; b = $urandom;
      if (i % 5 == 0) a = {a[0], 31'h7FFF_FFFF};
      if (i % 7 == 0) b = {1'b1, b[30:0]};
      k = 2'($urandom);
      doOp(a, b, k, int'($urandom % 32), 1'($urandom), 1'($urandom % 4 != 0),
           "R2 R7 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule